// File: doc/BRIEF.md
# Configurable Pseudo Dual-Port RAM

This block is a memory with one write port and one read port, each on its own clock. The storage pool is fixed at 16,384 bits. The parameter `DATA_W` picks the word width. The number of words and the address width follow from it: 16,384 words with 14 address bits at width 1, down to 512 words with 9 address bits at width 32.

The write side always registers its request (address, data, write enable and two chip selects) on an enabled write clock edge. The array commits the held request at the next enabled write edge. The read side registers its address and its output data by default, and parameters can bypass either register. Each port has a clock enable. Parameters can invert each clock and each enable.

All port registers are cleared by an asynchronous reset. That reset is the OR of an active-low global reset and a local reset whose active level is set by a parameter. Reset does not change the stored words.

Top module: `pdpram_top`

## Requirements
- R1: The array holds 16384/DATA_W words of DATA_W bits, where DATA_W is 1, 2, 4, 8, 16 or 32. With the default of 8 bits there are 2048 words, and address 0 and address 2047 hold independent words.
- R2: A request with `wr_en`=1, `wr_sel0`=1 and `wr_sel1`=1 is captured on an enabled write edge. Its data is stored at its address on the next enabled write edge.
- R3: A captured request with `wr_en`=0, or with either chip select at 0, leaves the array unchanged.
- R4: While `wr_cen` is inactive (low with default polarity), a write edge captures no request and commits nothing.
- R5: With both read registers present, the address is sampled on an enabled read edge. The word at that address appears on `rd_data` after the next enabled read edge.
- R6: While `rd_cen` is inactive, the read address register and `rd_data` hold their values.
- R7: If a registered read and a write commit target the same address on the same edge, the read returns the word that was stored before the write.
- R8: The effective reset is `glb_rst_n`=0 OR `loc_rst` at its active level (high with the default `LOC_RST_HIGH`=1). It clears the request, read-address and output registers at once, without waiting for a clock edge.
- R9: Stored words keep their values through any reset.
- R10: With both read registers bypassed, `rd_data` is the word at the current `rd_addr`, combinationally. A commit is visible right after the write edge that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_rst_n | input | 1 | Global asynchronous reset, active low |
| loc_rst | input | 1 | Local asynchronous reset, active level set by LOC_RST_HIGH |
| wr_clk | input | 1 | Write clock (optionally inverted) |
| wr_cen | input | 1 | Write clock enable (optionally inverted) |
| wr_en | input | 1 | Write enable, active high |
| wr_sel0 | input | 1 | First write chip select, active high |
| wr_sel1 | input | 1 | Second write chip select, active high |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read clock (optionally inverted) |
| rd_cen | input | 1 | Read clock enable (optionally inverted) |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data |

## Verification
The assertions assume that the reset inputs change only away from the active clock edges. They also assume that every address stays below the word count. The stimulus drives all inputs on the falling edge and draws addresses only from the valid range. Before comparing any read, the stimulus first writes every word, so no read sees an unwritten location. Random traffic often confines both addresses to a few low words, so same-address commit-and-read collisions happen often.

// File: rtl/pdpram_pkg.sv
// pdpram_pkg: shared geometry for the pseudo dual-port RAM.
// Assumes the word width is a power of two from 1 to 32.
package pdpram_pkg;
    localparam int unsigned PDP_POOL_BITS = 16384;

    // Number of words for a given word width.
    function automatic int unsigned pdp_words(input int unsigned width);
        return PDP_POOL_BITS / width;
    endfunction

    // True when the width is one of the supported ratios.
    function automatic bit pdp_width_ok(input int unsigned width);
        return (width == 1) || (width == 2) || (width == 4) ||
               (width == 8) || (width == 16) || (width == 32);
    endfunction
endpackage

// File: rtl/pdpram_wr_ctrl.sv
// pdpram_wr_ctrl: registers the write request on each enabled write edge
// and flags when the held request may be committed to the array.
// Assumes clk and cen arrive already polarity-corrected.
module pdpram_wr_ctrl #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          commit,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    logic       we_q;
    logic [1:0] sel_q;

    // Capture the full request on an enabled edge; async clear on reset.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            we_q   <= 1'b0;
            sel_q  <= 2'b00;
        end else if (cen) begin
            addr_q <= addr;
            data_q <= data;
            we_q   <= we;
            sel_q  <= sel;
        end
    end

    // A held request lands only on an enabled edge with every qualifier set.
    always_comb commit = cen && we_q && (sel_q == 2'b11);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cen |=> $stable({addr_q, data_q, we_q, sel_q}));

    // R3
    wr_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (cen && we && (sel == 2'b11)) |=> (we_q && (sel_q == 2'b11)));
endmodule

// File: rtl/pdpram_store.sv
// pdpram_store: the storage array with one synchronous write port and
// one combinational read port. Holds no reset, so contents survive it.
// Assumes addresses are below DEPTH.
module pdpram_store #(
    parameter int unsigned AW    = 11,
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 2048
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] mem [DEPTH];

    // Store the committed word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word without delay.
    always_comb rword = mem[raddr];

    // R2
    commit_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pdpram_rd_path.sv
// pdpram_rd_path: optional read-address register and optional output
// register, each picked by a parameter. Assumes clk and cen arrive
// already polarity-corrected.
module pdpram_rd_path #(
    parameter int unsigned AW       = 11,
    parameter int unsigned DW       = 8,
    parameter bit          ADDR_REG = 1'b1,
    parameter bit          DATA_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_eff,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] data_o
);
    generate
        if (ADDR_REG) begin : g_addr_reg
            logic [AW-1:0] addr_q;

            // Sample the read address on an enabled edge.
            always_ff @(posedge clk or posedge rst) begin
                if (rst)      addr_q <= '0;
                else if (cen) addr_q <= addr_i;
            end

            always_comb addr_eff = addr_q;

            // R5
            raddr_cap_chk: assert property (@(posedge clk) disable iff (rst)
                cen |=> (addr_q == $past(addr_i)));
            // R6
            raddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !cen |=> $stable(addr_q));
        end else begin : g_addr_flow
            // Pass the read address straight to the array.
            always_comb addr_eff = addr_i;
        end

        if (DATA_REG) begin : g_data_reg
            logic [DW-1:0] data_q;

            // Capture the array word on an enabled edge.
            always_ff @(posedge clk or posedge rst) begin
                if (rst)      data_q <= '0;
                else if (cen) data_q <= word_i;
            end

            always_comb data_o = data_q;

            // R6
            rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !cen |=> $stable(data_q));
            // R8
            rdata_clear_chk: assert property (@(posedge clk)
                rst |-> (data_q == '0));
        end else begin : g_data_flow
            // Pass the array word straight to the output.
            always_comb data_o = word_i;
        end
    endgenerate
endmodule

// File: rtl/pdpram_top.sv
// pdpram_top: pseudo dual-port RAM over a fixed 16,384-bit pool.
// Write side always registered; read side registers chosen by parameter.
// Assumes DATA_W is 1, 2, 4, 8, 16 or 32 and that the resets change away
// from clock edges.
module pdpram_top
    import pdpram_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter bit          RADDR_REG    = 1'b1,
    parameter bit          RDATA_REG    = 1'b1,
    parameter bit          LOC_RST_HIGH = 1'b1,
    parameter bit          WCLK_INV     = 1'b0,
    parameter bit          RCLK_INV     = 1'b0,
    parameter bit          WCEN_INV     = 1'b0,
    parameter bit          RCEN_INV     = 1'b0,
    localparam int unsigned DEPTH       = pdp_words(DATA_W),
    localparam int unsigned ADDR_W      = $clog2(DEPTH)
) (
    input  logic              glb_rst_n,
    input  logic              loc_rst,
    input  logic              wr_clk,
    input  logic              wr_cen,
    input  logic              wr_en,
    input  logic              wr_sel0,
    input  logic              wr_sel1,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_cen,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              rst_any;
    logic              wclk_g;
    logic              rclk_g;
    logic              wcen_g;
    logic              rcen_g;
    logic              commit;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] raddr_eff;
    logic [DATA_W-1:0] rword;

    // Merge the global and local resets into one async clear.
    always_comb rst_any = !glb_rst_n || (loc_rst == LOC_RST_HIGH);

    // Apply the per-port clock and enable polarity choices.
    always_comb begin
        wclk_g = wr_clk ^ WCLK_INV;
        rclk_g = rd_clk ^ RCLK_INV;
        wcen_g = wr_cen ^ WCEN_INV;
        rcen_g = rd_cen ^ RCEN_INV;
    end

    pdpram_wr_ctrl #(.AW(ADDR_W), .DW(DATA_W)) wr_u (
        .clk    (wclk_g),
        .rst    (rst_any),
        .cen    (wcen_g),
        .we     (wr_en),
        .sel    ({wr_sel1, wr_sel0}),
        .addr   (wr_addr),
        .data   (wr_data),
        .commit (commit),
        .addr_q (waddr_q),
        .data_q (wdata_q)
    );

    pdpram_store #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) mem_u (
        .clk   (wclk_g),
        .rst   (rst_any),
        .we    (commit),
        .waddr (waddr_q),
        .wdata (wdata_q),
        .raddr (raddr_eff),
        .rword (rword)
    );

    pdpram_rd_path #(
        .AW(ADDR_W), .DW(DATA_W), .ADDR_REG(RADDR_REG), .DATA_REG(RDATA_REG)
    ) rd_u (
        .clk      (rclk_g),
        .rst      (rst_any),
        .cen      (rcen_g),
        .addr_i   (rd_addr),
        .addr_eff (raddr_eff),
        .word_i   (rword),
        .data_o   (rd_data)
    );

    // R1
    width_ok_chk: assert property (@(posedge wclk_g) disable iff (rst_any)
        pdp_width_ok(DATA_W) && (DEPTH * DATA_W == PDP_POOL_BITS));
endmodule

// File: tb/pdpram_top_tb_top.sv
// Bench for pdpram_top: one instance in the default registered-read
// configuration and one with both read registers bypassed, on shared inputs.
module pdpram_top_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 16384 / DW;
    localparam int AW    = $clog2(DEPTH);

    logic          clk       = 1'b0;
    logic          glb_rst_n = 1'b0;
    logic          loc_rst   = 1'b0;
    logic          wr_cen    = 1'b0;
    logic          wr_en     = 1'b0;
    logic          wr_sel0   = 1'b0;
    logic          wr_sel1   = 1'b0;
    logic [AW-1:0] wr_addr   = '0;
    logic [DW-1:0] wr_data   = '0;
    logic          rd_cen    = 1'b0;
    logic [AW-1:0] rd_addr   = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] rd_data_ft;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Requirement-level model state.
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_wa, m_ra;
    logic [DW-1:0] m_wd, m_rd;
    logic          m_we;
    logic [1:0]    m_sel;

    always #5 clk = ~clk;

    pdpram_top #(.DATA_W(DW)) dut_i (
        .glb_rst_n(glb_rst_n), .loc_rst(loc_rst),
        .wr_clk(clk), .wr_cen(wr_cen), .wr_en(wr_en),
        .wr_sel0(wr_sel0), .wr_sel1(wr_sel1),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(clk), .rd_cen(rd_cen), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pdpram_top #(.DATA_W(DW), .RADDR_REG(1'b0), .RDATA_REG(1'b0)) dut_ft_i (
        .glb_rst_n(glb_rst_n), .loc_rst(loc_rst),
        .wr_clk(clk), .wr_cen(wr_cen), .wr_en(wr_en),
        .wr_sel0(wr_sel0), .wr_sel1(wr_sel1),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(clk), .rd_cen(rd_cen), .rd_addr(rd_addr), .rd_data(rd_data_ft)
    );

    task automatic model_reset();
        m_wa = '0; m_wd = '0; m_we = 1'b0; m_sel = 2'b00;
        m_ra = '0; m_rd = '0;
    endtask

    // Apply one rising edge to the model, from the requirements.
    task automatic model_edge();
        logic [DW-1:0] nxt_rd;
        if (!glb_rst_n || loc_rst) begin
            model_reset();
        end else begin
            nxt_rd = m_rd;
            if (rd_cen) nxt_rd = m_mem[m_ra];
            if (wr_cen) begin
                if (m_we && m_sel == 2'b11) m_mem[m_wa] = m_wd;
                m_wa = wr_addr; m_wd = wr_data; m_we = wr_en;
                m_sel = {wr_sel1, wr_sel0};
            end
            if (rd_cen) m_ra = rd_addr;
            m_rd = nxt_rd;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_sel0 = 1'b0; wr_sel1 = 1'b0;
        wr_cen = 1'b1; rd_cen = 1'b1;
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic en, input logic s0, input logic s1);
        wr_addr = a; wr_data = d; wr_en = en; wr_sel0 = s0; wr_sel1 = s1;
        tick();
        idle();
        tick();
    endtask

    task automatic fetch(input logic [AW-1:0] a);
        rd_addr = a;
        tick();
        tick();
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        @(negedge clk);
        tick();
        // R8: reset state of the registered output
        chk(rd_data, '0, "R8 reset state");
        glb_rst_n = 1'b1;
        idle();

        // Fill every word so later reads are defined.
        for (int i = 0; i < DEPTH; i++) begin
            wr_addr = AW'(i); wr_data = DW'(i * 37 + 11);
            wr_en = 1'b1; wr_sel0 = 1'b1; wr_sel1 = 1'b1;
            tick();
        end
        idle();
        tick();

        // R2: a qualified write lands
        put(AW'(5), 8'hA5, 1'b1, 1'b1, 1'b1);
        fetch(AW'(5));
        chk(rd_data, 8'hA5, "R2 write then read");
        chk(rd_data, m_rd, "R5 registered read latency");

        // R1: both ends of the 2048-word range are independent
        put(AW'(DEPTH - 1), 8'h3C, 1'b1, 1'b1, 1'b1);
        put(AW'(0), 8'hC3, 1'b1, 1'b1, 1'b1);
        fetch(AW'(DEPTH - 1));
        chk(rd_data, 8'h3C, "R1 top word");
        fetch(AW'(0));
        chk(rd_data, 8'hC3, "R1 word zero");

        // R3: each missing qualifier blocks the write
        put(AW'(5), 8'h11, 1'b0, 1'b1, 1'b1);
        put(AW'(5), 8'h12, 1'b1, 1'b0, 1'b1);
        put(AW'(5), 8'h13, 1'b1, 1'b1, 1'b0);
        fetch(AW'(5));
        chk(rd_data, 8'hA5, "R3 unqualified writes ignored");

        // R4: write clock enable low captures nothing
        wr_cen = 1'b0;
        wr_addr = AW'(5); wr_data = 8'h22;
        wr_en = 1'b1; wr_sel0 = 1'b1; wr_sel1 = 1'b1;
        tick();
        idle();
        tick();
        tick();
        fetch(AW'(5));
        chk(rd_data, 8'hA5, "R4 disabled write edge");

        // R6: read enable low holds the output
        rd_cen = 1'b0;
        rd_addr = AW'(0);
        tick(); tick(); tick();
        chk(rd_data, 8'hA5, "R6 output held");
        rd_cen = 1'b1;
        tick();
        tick();
        chk(rd_data, 8'hC3, "R6 held address then release");

        // R7: same-address commit and read return the old word
        put(AW'(9), 8'h77, 1'b1, 1'b1, 1'b1);
        fetch(AW'(9));
        wr_addr = AW'(9); wr_data = 8'h99;
        wr_en = 1'b1; wr_sel0 = 1'b1; wr_sel1 = 1'b1;
        tick();
        idle();
        tick();
        chk(rd_data, 8'h77, "R7 old data on collision");
        tick();
        chk(rd_data, 8'h99, "R7 new data next edge");

        // R10: flow-through follows the address at once
        rd_addr = AW'(5);
        #1;
        chk(rd_data_ft, 8'hA5, "R10 flow-through word");
        rd_addr = AW'(9);
        #1;
        chk(rd_data_ft, 8'h99, "R10 flow-through new address");
        @(negedge clk);

        // R8: local reset clears output with no clock edge
        loc_rst = 1'b1;
        #1;
        chk(rd_data, '0, "R8 local async clear");
        tick();
        loc_rst = 1'b0;
        fetch(AW'(9));
        // R8: global reset clears output with no clock edge
        glb_rst_n = 1'b0;
        #1;
        chk(rd_data, '0, "R8 global async clear");
        tick();
        glb_rst_n = 1'b1;

        // R9: contents survive both resets
        fetch(AW'(5));
        chk(rd_data, 8'hA5, "R9 word kept through reset");
        fetch(AW'(DEPTH - 1));
        chk(rd_data, 8'h3C, "R9 top word kept through reset");

        // Random traffic with frequent address collisions.
        for (int n = 0; n < 3000; n++) begin
            logic narrow;
            narrow  = ($urandom_range(0, 2) == 0);
            wr_addr = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, DEPTH - 1));
            rd_addr = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, DEPTH - 1));
            wr_data = DW'($urandom);
            wr_en   = ($urandom_range(0, 9) < 7);
            wr_sel0 = ($urandom_range(0, 9) < 9);
            wr_sel1 = ($urandom_range(0, 9) < 9);
            wr_cen  = ($urandom_range(0, 9) < 8);
            rd_cen  = ($urandom_range(0, 9) < 8);
            tick();
            chk(rd_data, m_rd, "R5 random registered read");
            chk(rd_data_ft, m_mem[rd_addr], "R10 random flow-through read");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule